// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The controller gathers interrupt requests from a set of sources and decides, every cycle, whether the processor should take an interrupt. Each source has a pending flag, an enable bit and a three-bit priority. A source may fire only when it is pending, enabled and strictly above the processor's current priority level. The highest such level wins, and a tie goes to the lowest source number. A global enable gates every take.

On a take, the block does four things. It pulses a one-cycle strobe. It registers the winning vector number and priority. It raises the current processor level to that priority. It computes the entry address from a programmable exception base and vector spacing. In single-vector mode every source shares one entry. In multi-vector mode each source has its own slot. A programmable shadow level marks which priority uses the single shadow register file rather than a software context save; the block reports this as a shadow-select flag on the take.

A bootstrap bit redirects all exceptions to a fixed address. The block also supplies the entry address for general, non-interrupt exceptions. Software reaches the small register set through a one-cycle write port and clears pending flags through a write-one-to-clear vector.

Top module: `vpic_top`

## Requirements
- R1: A high `src_req[i]` sets pending flag i, shown on `irq_pending[i]`. The flag holds until a one on `flag_clr[i]` clears it. When a request and a clear hit the same flag in the same cycle, the flag stays set.
- R2: No interrupt is taken while the global enable is clear. The global enable is bit 0 of the control register, at select 0. It is clear after reset.
- R3: After reset the block is in this state:
  - `cpu_ipl` is 0 and no flag is pending.
  - The exception base is 0x9FC01000 and the spacing field is 1.
  - The mode is single-vector, the bootstrap bit is clear and the shadow level is 0.
- R4: Source i is eligible only when its flag is set, `src_en[i]` is 1, and its priority `src_prio[3i+2:3i]` is strictly greater than `cpu_ipl`.
- R5: Among the eligible sources the highest priority wins. Equal priorities resolve to the lowest source index.
- R6: A take happens in the cycle after a source becomes eligible with the global enable set. On a take, all of the following hold:
  - `irq_take` is high for that one cycle only.
  - `irq_vec`, `irq_ipl`, `irq_addr` and `irq_shadow` hold the winner's values.
  - `cpu_ipl` becomes the winner's priority.
  - The winner's flag stays set.
- R7: In single-vector mode, with control bit 1 clear, `irq_addr` is base + 0x200.
- R8: In multi-vector mode, with control bit 1 set, `irq_addr` is base + 0x200 + vector × (spacing field × 32). The base is written at select 1. The five-bit spacing field is written at select 2.
- R9: With the bootstrap bit (control bit 2) clear, `gen_exc_addr` is base + 0x180.
- R10: With the bootstrap bit set, both `gen_exc_addr` and `irq_addr` are 0xBFC00380.
- R11: `irq_shadow` is 1 exactly when the taken priority equals the shadow level. The shadow level is written at select 3, in bits 2:0.
- R12: A write at select 4 loads `cpu_ipl` from bits 2:0. When a take occurs in the same cycle, the winner's level is loaded instead.
- R13: A source whose priority is above the level raised by an earlier take is taken at once. This is nested preemption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Per-source request, sets the pending flag |
| flag_clr | input | NUM_SRC | Write-one-to-clear of pending flags |
| src_en | input | NUM_SRC | Per-source enable |
| src_prio | input | 3*NUM_SRC | Per-source priority, source i in bits 3i+2:3i |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 base, 2 spacing, 3 shadow level, 4 current level |
| cfg_wdata | input | 32 | Configuration write data |
| irq_pending | output | NUM_SRC | Pending flags |
| cpu_ipl | output | 3 | Current processor priority level |
| irq_take | output | 1 | One-cycle take strobe |
| irq_vec | output | clog2(NUM_SRC) | Vector number of the taken source |
| irq_ipl | output | 3 | Priority of the taken source |
| irq_addr | output | 32 | Entry address of the taken interrupt |
| irq_shadow | output | 1 | Shadow register file select for the taken interrupt |
| gen_exc_addr | output | 32 | Entry address for general exceptions |

## Verification
Two actions can land on the same state in one cycle.

The first is a request and a write-one-to-clear arriving together on one pending flag. The bench drives both in the same cycle and expects the flag to survive.

The second is a take and a software write of the current level. The bench makes a source eligible and issues the level write in the very cycle the take fires. It then expects `cpu_ipl` to show the winner's priority, not the written value.

// File: rtl/vpic_pkg.sv
// Shared constants and types for the vectored priority interrupt controller.
// Assumes 32-bit addresses and a three-bit priority field.
package vpic_pkg;
    localparam int ADDR_W = 32;
    localparam int IPL_W  = 3;
    localparam int SPC_W  = 5;

    localparam logic [ADDR_W-1:0] BOOT_EXC_ADDR = 32'hBFC0_0380;
    localparam logic [ADDR_W-1:0] RST_EXC_BASE  = 32'h9FC0_1000;
    localparam logic [ADDR_W-1:0] GEN_OFS       = 32'h0000_0180;
    localparam logic [ADDR_W-1:0] IRQ_OFS       = 32'h0000_0200;
    localparam int                SLOT_SHIFT    = 5;

    typedef enum logic [2:0] {
        CFG_CTRL   = 3'd0,
        CFG_BASE   = 3'd1,
        CFG_SPACE  = 3'd2,
        CFG_SHADOW = 3'd3,
        CFG_IPL    = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic bev;
        logic multi;
        logic gie;
    } ctrl_t;
endpackage

// File: rtl/vpic_flags.sv
// Pending-flag bank: a request sets a flag, a write-one-to-clear removes it.
// Assumes set has precedence over clear in the same cycle.
module vpic_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_q;

    // Update every flag: clear first, then apply new requests on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R1
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0)); // R1
endmodule

// File: rtl/vpic_arbiter.sv
// Combinational priority arbiter: picks the highest eligible level, lowest index on ties.
// Assumes eligibility requires flag, enable and a level strictly above the current one.
module vpic_arbiter
    import vpic_pkg::*;
#(
    parameter int N     = 8,
    parameter int VEC_W = 3
) (
    input  logic [N-1:0]       flags_i,
    input  logic [N-1:0]       en_i,
    input  logic [N*IPL_W-1:0] prio_i,
    input  logic [IPL_W-1:0]   cur_ipl_i,
    output logic               found_o,
    output logic [VEC_W-1:0]   win_idx_o,
    output logic [IPL_W-1:0]   win_ipl_o
);
    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = flags_i[g] & en_i[g] & (prio_i[g*IPL_W +: IPL_W] > cur_ipl_i);
    end

    // Scan from the top index down so that an equal level at a lower index replaces the holder.
    always_comb begin
        logic             hit;
        logic [VEC_W-1:0] idx;
        logic [IPL_W-1:0] lvl;
        hit = 1'b0;
        idx = '0;
        lvl = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && (!hit || prio_i[i*IPL_W +: IPL_W] >= lvl)) begin
                hit = 1'b1;
                idx = VEC_W'(i);
                lvl = prio_i[i*IPL_W +: IPL_W];
            end
        end
        found_o   = hit;
        win_idx_o = idx;
        win_ipl_o = lvl;
    end
endmodule

// File: rtl/vpic_vector.sv
// Entry-address generator for interrupts and general exceptions.
// Assumes the spacing field counts 32-byte slots and the bootstrap bit overrides everything.
module vpic_vector
    import vpic_pkg::*;
#(
    parameter int VEC_W = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SPC_W-1:0]  spacing_i,
    input  logic              multi_i,
    input  logic              bev_i,
    input  logic [VEC_W-1:0]  vec_i,
    output logic [ADDR_W-1:0] irq_addr_o,
    output logic [ADDR_W-1:0] gen_addr_o
);
    logic [ADDR_W-1:0] slot_bytes;
    logic [ADDR_W-1:0] slot_ofs;

    assign slot_bytes = ADDR_W'(spacing_i) << SLOT_SHIFT;

    // Per-vector offset is applied only in multi-vector mode.
    always_comb begin
        slot_ofs = multi_i ? (ADDR_W'(vec_i) * slot_bytes) : '0;
    end

    // Bootstrap mode sends every exception to the fixed address.
    always_comb begin
        if (bev_i) begin
            irq_addr_o = BOOT_EXC_ADDR;
            gen_addr_o = BOOT_EXC_ADDR;
        end else begin
            irq_addr_o = base_i + IRQ_OFS + slot_ofs;
            gen_addr_o = base_i + GEN_OFS;
        end
    end
endmodule

// File: rtl/vpic_top.sv
// Vectored priority interrupt controller top: configuration registers, current level,
// take stage and shadow selection. Assumes synchronous active-low reset and that
// software lowers the current level through the level register on handler exit.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int VEC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC-1:0]       flag_clr,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic [NUM_SRC*IPL_W-1:0] src_prio,
    input  logic                     cfg_wr,
    input  logic [2:0]               cfg_sel,
    input  logic [31:0]              cfg_wdata,
    output logic [NUM_SRC-1:0]       irq_pending,
    output logic [IPL_W-1:0]         cpu_ipl,
    output logic                     irq_take,
    output logic [VEC_W-1:0]         irq_vec,
    output logic [IPL_W-1:0]         irq_ipl,
    output logic [ADDR_W-1:0]        irq_addr,
    output logic                     irq_shadow,
    output logic [ADDR_W-1:0]        gen_exc_addr
);
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] base_q;
    logic [SPC_W-1:0]  spacing_q;
    logic [IPL_W-1:0]  shadow_lvl_q;
    logic [IPL_W-1:0]  cur_ipl_q;

    logic              found;
    logic [VEC_W-1:0]  win_idx;
    logic [IPL_W-1:0]  win_ipl;
    logic              take_now;
    logic [ADDR_W-1:0] entry_addr;
    logic              wr_ipl;

    vpic_flags #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_req),
        .clr_i   (flag_clr),
        .flags_o (irq_pending)
    );

    vpic_arbiter #(.N(NUM_SRC), .VEC_W(VEC_W)) u_arb (
        .flags_i   (irq_pending),
        .en_i      (src_en),
        .prio_i    (src_prio),
        .cur_ipl_i (cur_ipl_q),
        .found_o   (found),
        .win_idx_o (win_idx),
        .win_ipl_o (win_ipl)
    );

    vpic_vector #(.VEC_W(VEC_W)) u_vec (
        .base_i     (base_q),
        .spacing_i  (spacing_q),
        .multi_i    (ctrl_q.multi),
        .bev_i      (ctrl_q.bev),
        .vec_i      (win_idx),
        .irq_addr_o (entry_addr),
        .gen_addr_o (gen_exc_addr)
    );

    assign take_now = ctrl_q.gie & found;
    assign wr_ipl   = cfg_wr && (cfg_sel_e'(cfg_sel) == CFG_IPL);

    // Configuration registers written through the select/data port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            base_q       <= RST_EXC_BASE;
            spacing_q    <= SPC_W'(1);
            shadow_lvl_q <= '0;
        end else if (cfg_wr) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_CTRL:   ctrl_q       <= ctrl_t'(cfg_wdata[2:0]);
                CFG_BASE:   base_q       <= cfg_wdata;
                CFG_SPACE:  spacing_q    <= cfg_wdata[SPC_W-1:0];
                CFG_SHADOW: shadow_lvl_q <= cfg_wdata[IPL_W-1:0];
                default:    ;
            endcase
        end
    end

    // Current processor level: a take raises it and overrides a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_ipl_q <= '0;
        else if (take_now) cur_ipl_q <= win_ipl;
        else if (wr_ipl)   cur_ipl_q <= cfg_wdata[IPL_W-1:0];
    end

    // Take stage: one-cycle strobe and the winner's registered attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take   <= 1'b0;
            irq_vec    <= '0;
            irq_ipl    <= '0;
            irq_addr   <= '0;
            irq_shadow <= 1'b0;
        end else begin
            irq_take <= take_now;
            if (take_now) begin
                irq_vec    <= win_idx;
                irq_ipl    <= win_ipl;
                irq_addr   <= entry_addr;
                irq_shadow <= (win_ipl == shadow_lvl_q);
            end
        end
    end

    assign cpu_ipl = cur_ipl_q;

    AST_GIE_GATES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.gie |=> !irq_take); // R2
    AST_TAKE_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
        take_now |-> (win_ipl > cur_ipl_q)); // R4
    AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (irq_pending[win_idx] && src_en[win_idx])); // R5
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (!irq_take || (irq_ipl > $past(irq_ipl)))); // R6
    AST_SHADOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        take_now |=> (irq_shadow == (irq_ipl == $past(shadow_lvl_q)))); // R11
    AST_BOOT_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.bev |-> (gen_exc_addr == BOOT_EXC_ADDR)); // R10
endmodule

// File: tb/tb_vpic_top.sv
`timescale 1ns/1ps
module tb_vpic_top;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  src_req, flag_clr, src_en;
    logic [N*3-1:0] src_prio;
    logic          cfg_wr;
    logic [2:0]    cfg_sel;
    logic [31:0]   cfg_wdata;
    logic [N-1:0]  irq_pending;
    logic [2:0]    cpu_ipl, irq_ipl;
    logic          irq_take, irq_shadow;
    logic [2:0]    irq_vec;
    logic [31:0]   irq_addr, gen_exc_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    vpic_top #(.NUM_SRC(N)) dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .flag_clr(flag_clr),
        .src_en(src_en), .src_prio(src_prio), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .irq_pending(irq_pending), .cpu_ipl(cpu_ipl),
        .irq_take(irq_take), .irq_vec(irq_vec), .irq_ipl(irq_ipl),
        .irq_addr(irq_addr), .irq_shadow(irq_shadow), .gen_exc_addr(gen_exc_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic raise(input logic [N-1:0] mask);
        src_req = mask;
        step();
        src_req = '0;
    endtask

    task automatic clear(input logic [N-1:0] mask);
        flag_clr = mask;
        step();
        flag_clr = '0;
    endtask

    task automatic set_prio(input int idx, input logic [2:0] p);
        src_prio[idx*3 +: 3] = p;
    endtask

    task automatic cleanup();
        src_en = '0;
        clear('1);
        cfg_write(3'd4, 32'd0);
    endtask

    task automatic t_reset();
        check("R3", "take", {31'b0, irq_take}, 32'd0);
        check("R3", "cpu_ipl", {29'b0, cpu_ipl}, 32'd0);
        check("R3", "pending", {24'b0, irq_pending}, 32'd0);
        check("R9", "gen addr", gen_exc_addr, 32'h9FC0_1180);
    endtask

    task automatic t_global_enable();
        src_en = 8'b0000_0100; set_prio(2, 3'd3);
        raise(8'b0000_0100);
        check("R1", "flag set", {31'b0, irq_pending[2]}, 32'd1);
        step();
        check("R2", "no take gie=0", {31'b0, irq_take}, 32'd0);
        step();
        check("R2", "no take gie=0 later", {31'b0, irq_take}, 32'd0);
        cfg_write(3'd0, 32'h1);
        step();
        check("R6", "take", {31'b0, irq_take}, 32'd1);
        check("R6", "vec", {29'b0, irq_vec}, 32'd2);
        check("R6", "ipl", {29'b0, irq_ipl}, 32'd3);
        check("R6", "cpu_ipl raised", {29'b0, cpu_ipl}, 32'd3);
        check("R7", "single addr", irq_addr, 32'h9FC0_1200);
        step();
        check("R6", "strobe drops", {31'b0, irq_take}, 32'd0);
        check("R6", "flag held", {31'b0, irq_pending[2]}, 32'd1);
        clear(8'b0000_0100);
        check("R1", "w1c clears", {31'b0, irq_pending[2]}, 32'd0);
        cleanup();
    endtask

    task automatic t_strict();
        cfg_write(3'd4, 32'd3);
        check("R12", "sw write ipl", {29'b0, cpu_ipl}, 32'd3);
        src_en = 8'b0010_0000; set_prio(5, 3'd3); set_prio(6, 3'd7);
        raise(8'b0010_0000);
        step();
        check("R4", "equal level not taken", {31'b0, irq_take}, 32'd0);
        raise(8'b0100_0000);
        step();
        check("R4", "disabled not taken", {31'b0, irq_take}, 32'd0);
        check("R4", "both pending", {24'b0, irq_pending}, 32'h60);
        cleanup();
    endtask

    task automatic t_arbitration();
        cfg_write(3'd0, 32'h3);
        src_en = 8'b0101_0010; set_prio(1, 3'd5); set_prio(4, 3'd5); set_prio(6, 3'd3);
        raise(8'b0101_0010);
        step();
        check("R5", "tie lowest index", {29'b0, irq_vec}, 32'd1);
        check("R5", "winner level", {29'b0, irq_ipl}, 32'd5);
        check("R8", "multi addr vec1", irq_addr, 32'h9FC0_1220);
        step();
        check("R4", "same level no retake", {31'b0, irq_take}, 32'd0);
        clear(8'b0000_0010);
        cfg_write(3'd4, 32'd0);
        step();
        check("R5", "next winner take", {31'b0, irq_take}, 32'd1);
        check("R5", "next winner vec", {29'b0, irq_vec}, 32'd4);
        check("R8", "multi addr vec4", irq_addr, 32'h9FC0_1280);
        cleanup();
    endtask

    task automatic t_spacing_base();
        cfg_write(3'd2, 32'd2);
        src_en = 8'b0010_0000; set_prio(5, 3'd2);
        raise(8'b0010_0000);
        step();
        check("R8", "spacing 64 vec5", irq_addr, 32'h9FC0_1340);
        cleanup();
        cfg_write(3'd1, 32'h8000_0000);
        check("R9", "gen addr new base", gen_exc_addr, 32'h8000_0180);
        src_en = 8'b0010_0000;
        raise(8'b0010_0000);
        step();
        check("R8", "new base vec5", irq_addr, 32'h8000_0340);
        cleanup();
        cfg_write(3'd1, 32'h9FC0_1000);
        cfg_write(3'd2, 32'd1);
    endtask

    task automatic t_shadow();
        cfg_write(3'd3, 32'd4);
        src_en = 8'b0000_1000; set_prio(3, 3'd4);
        raise(8'b0000_1000);
        step();
        check("R11", "shadow at level", {31'b0, irq_shadow}, 32'd1);
        cleanup();
        src_en = 8'b0000_1000; set_prio(3, 3'd2);
        raise(8'b0000_1000);
        step();
        check("R11", "take at other level", {31'b0, irq_take}, 32'd1);
        check("R11", "no shadow other level", {31'b0, irq_shadow}, 32'd0);
        cleanup();
    endtask

    task automatic t_preempt();
        src_en = 8'b1000_0001; set_prio(0, 3'd2); set_prio(7, 3'd6);
        raise(8'b0000_0001);
        step();
        check("R6", "low take level", {29'b0, irq_ipl}, 32'd2);
        step();
        raise(8'b1000_0000);
        step();
        check("R13", "preempt take", {31'b0, irq_take}, 32'd1);
        check("R13", "preempt vec", {29'b0, irq_vec}, 32'd7);
        check("R13", "preempt cpu_ipl", {29'b0, cpu_ipl}, 32'd6);
        cleanup();
    endtask

    task automatic t_flag_collision();
        src_en = '0;
        raise(8'b0000_0100);
        src_req = 8'b0000_0100; flag_clr = 8'b0000_0100;
        step();
        src_req = '0; flag_clr = '0;
        check("R1", "set beats clear", {31'b0, irq_pending[2]}, 32'd1);
        clear(8'b0000_0100);
        check("R1", "clear after collision", {31'b0, irq_pending[2]}, 32'd0);
    endtask

    task automatic t_ipl_collision();
        src_en = 8'b0000_0010; set_prio(1, 3'd6);
        raise(8'b0000_0010);
        cfg_write(3'd4, 32'd1);
        check("R12", "take in write cycle", {31'b0, irq_take}, 32'd1);
        check("R12", "take beats sw write", {29'b0, cpu_ipl}, 32'd6);
        cleanup();
    endtask

    task automatic t_bootstrap();
        cfg_write(3'd0, 32'h7);
        check("R10", "gen addr bootstrap", gen_exc_addr, 32'hBFC0_0380);
        src_en = 8'b0000_0100; set_prio(2, 3'd3);
        raise(8'b0000_0100);
        step();
        check("R10", "take in bootstrap", {31'b0, irq_take}, 32'd1);
        check("R10", "irq addr bootstrap", irq_addr, 32'hBFC0_0380);
        cleanup();
    endtask

    initial begin
        rst_n = 1'b0; src_req = '0; flag_clr = '0; src_en = '0; src_prio = '0;
        cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_global_enable();
        t_strict();
        t_flag_collision();
        t_ipl_collision();
        t_arbitration();
        t_spacing_base();
        t_shadow();
        t_preempt();
        t_bootstrap();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule